// File: doc/BRIEF.md
# Overrange Flag with Hysteresis and Dwell Release

This block watches a stream of sample magnitudes and drives one overrange pin. A sample whose magnitude is strictly above a set threshold raises an internal flag at once. The flag is released only after enough consecutive samples have stayed strictly below a separate, lower release threshold. The number of samples required is a programmable 16-bit dwell value. This hysteresis keeps the pin from chattering while the signal hovers near its limit.

Both thresholds arrive as a pair of byte registers each and are assembled inside the block. The high byte supplies only its five low bits. The dwell value is built from two full bytes. A sample strobe marks each sample of the post-divider sample rate, so the dwell is counted in samples and not in clock cycles. A detect-enable bit gates the comparator onto the pin. A debug override drives the pin to a written value whatever the flag holds.

Top module: `fd_hyst_flag`

## Requirements
- R1: The set threshold is {set_hi[4:0], set_lo} and the release threshold is {rel_hi[4:0], rel_lo}, both 13 bits. Bits 7:5 of the high bytes have no effect. The dwell is {dwell_hi, dwell_lo}, 16 bits.
- R2: With det_en high, a sample (smp_vld high) whose magnitude is strictly greater than the set threshold raises the flag. The flag is visible on fd_o after that clock edge. A magnitude equal to the threshold does not raise it.
- R3: While the flag is set, it clears on the (D+1)-th consecutive valid sample with magnitude strictly below the release threshold, where D is the dwell value. It stays set through the first D such samples.
- R4: While the flag is set, a valid sample at or above the release threshold restarts the dwell count from zero.
- R5: With a dwell of 0, the first valid sample below the release threshold clears the flag.
- R6: A sample above the set threshold keeps the flag set even when it would also complete the dwell, for example when the release threshold lies above the set threshold.
- R7: Clock cycles with smp_vld low change neither the flag nor the dwell count.
- R8: With det_en low, the flag and the dwell count are cleared at the next clock edge, and fd_o is low unless forced.
- R9: With frc_en high, fd_o equals frc_val combinationally, whatever det_en and the flag hold.
- R10: During and after reset (rst_n low), the flag is clear and fd_o is low when not forced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe at the post-divider rate |
| smp_mag | input | 13 | Sample magnitude |
| set_hi | input | 8 | Set threshold, high byte (bits 4:0 used) |
| set_lo | input | 8 | Set threshold, low byte |
| rel_hi | input | 8 | Release threshold, high byte (bits 4:0 used) |
| rel_lo | input | 8 | Release threshold, low byte |
| dwell_hi | input | 8 | Dwell count, high byte |
| dwell_lo | input | 8 | Dwell count, low byte |
| det_en | input | 1 | Detect enable; gates the comparator onto the pin |
| frc_en | input | 1 | Debug override enable |
| frc_val | input | 1 | Value driven on the pin during override |
| fd_o | output | 1 | Overrange pin |

## Verification
Flag and dwell state update on the clock edge at which a strobed sample is presented. fd_o therefore reflects that sample one register later. The override and the enable gate act on fd_o combinationally with no delay. The bench drives every input on the falling edge. It samples fd_o one nanosecond after the rising edge that follows a sample. Force and enable changes are sampled one nanosecond after they are applied, with no edge in between. Between samples the strobe is lowered, so no clock edge adds an unintended sample to the bench's model.

// File: rtl/fd_hyst_pkg.sv
package fd_hyst_pkg;
    localparam int REG_W   = 8;
    localparam int MAG_W   = 13;
    localparam int DWELL_W = 16;

    typedef struct packed {
        logic above;
        logic below;
    } cmp_t;
endpackage

// File: rtl/fd_thr_asm.sv
module fd_thr_asm #(
    parameter int REG_W = 8,
    parameter int OUT_W = 13
) (
    input  logic [REG_W-1:0] hi_byte,
    input  logic [REG_W-1:0] lo_byte,
    output logic [OUT_W-1:0] value
);
    localparam int HI_W = OUT_W - REG_W;

    assign value = {hi_byte[HI_W-1:0], lo_byte};

    generate
        if (HI_W < REG_W) begin : g_spare
            logic unused_spare;
            assign unused_spare = ^hi_byte[REG_W-1:HI_W];
        end
    endgenerate
endmodule

// File: rtl/fd_cmp.sv
module fd_cmp
    import fd_hyst_pkg::*;
#(
    parameter int W = 13
) (
    input  logic [W-1:0] mag,
    input  logic [W-1:0] thr_set,
    input  logic [W-1:0] thr_rel,
    output cmp_t         res
);
    always_comb begin
        res.above = (mag > thr_set);
        res.below = (mag < thr_rel);
    end
endmodule

// File: rtl/fd_flag_fsm.sv
module fd_flag_fsm
    import fd_hyst_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             det_en,
    input  logic             valid,
    input  cmp_t             cmp,
    input  logic [CNT_W-1:0] dwell,
    output logic             flag
);
    typedef struct packed {
        logic             flag;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!det_en) begin
            st_d = '0;
        end else if (valid) begin
            if (cmp.above) begin
                st_d.flag = 1'b1;
                st_d.cnt  = '0;
            end else if (st_q.flag && cmp.below) begin
                if (st_q.cnt >= dwell) st_d = '0;
                else st_d.cnt = st_q.cnt + CNT_W'(1);
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    // R2
    set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(valid && cmp.above && det_en));

    // R3
    release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.flag) |-> ($past(!det_en) ||
                              $past(valid && cmp.below && !cmp.above && st_q.cnt >= dwell)));

    // R4
    cnt_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) |-> st_q.flag);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (det_en && !valid) |=> $stable(st_q));

    // R8
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en |=> (st_q == '0));
endmodule

// File: rtl/fd_hyst_flag.sv
module fd_hyst_flag
    import fd_hyst_pkg::*;
#(
    parameter int MAG_BITS   = MAG_W,
    parameter int DWELL_BITS = DWELL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_vld,
    input  logic [MAG_BITS-1:0] smp_mag,
    input  logic [REG_W-1:0]    set_hi,
    input  logic [REG_W-1:0]    set_lo,
    input  logic [REG_W-1:0]    rel_hi,
    input  logic [REG_W-1:0]    rel_lo,
    input  logic [REG_W-1:0]    dwell_hi,
    input  logic [REG_W-1:0]    dwell_lo,
    input  logic                det_en,
    input  logic                frc_en,
    input  logic                frc_val,
    output logic                fd_o
);
    logic [MAG_BITS-1:0]   thr_set, thr_rel;
    logic [DWELL_BITS-1:0] dwell;
    cmp_t                  cmp;
    logic                  flag;

    fd_thr_asm #(.REG_W(REG_W), .OUT_W(MAG_BITS)) u_set_asm (
        .hi_byte(set_hi), .lo_byte(set_lo), .value(thr_set));

    fd_thr_asm #(.REG_W(REG_W), .OUT_W(MAG_BITS)) u_rel_asm (
        .hi_byte(rel_hi), .lo_byte(rel_lo), .value(thr_rel));

    fd_thr_asm #(.REG_W(REG_W), .OUT_W(DWELL_BITS)) u_dwell_asm (
        .hi_byte(dwell_hi), .lo_byte(dwell_lo), .value(dwell));

    fd_cmp #(.W(MAG_BITS)) u_cmp (
        .mag(smp_mag), .thr_set(thr_set), .thr_rel(thr_rel), .res(cmp));

    fd_flag_fsm #(.CNT_W(DWELL_BITS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .det_en(det_en), .valid(smp_vld),
        .cmp(cmp), .dwell(dwell), .flag(flag));

    always_comb begin
        if (frc_en)      fd_o = frc_val;
        else if (det_en) fd_o = flag;
        else             fd_o = 1'b0;
    end
endmodule

// File: tb/fd_hyst_flag_bench.sv
module fd_hyst_flag_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [12:0] smp_mag = '0;
    logic [7:0]  set_hi = '0, set_lo = '0, rel_hi = '0, rel_lo = '0;
    logic [7:0]  dwell_hi = '0, dwell_lo = '0;
    logic        det_en = 1'b0, frc_en = 1'b0, frc_val = 1'b0;
    logic        fd_o;

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    logic [12:0] mU = '0, mL = '0;
    logic [15:0] mD = '0;
    bit          mf = 0;
    int          mc = 0;

    always #2 clk = ~clk;

    fd_hyst_flag u_fd_hyst_flag (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_mag(smp_mag),
        .set_hi(set_hi), .set_lo(set_lo), .rel_hi(rel_hi), .rel_lo(rel_lo),
        .dwell_hi(dwell_hi), .dwell_lo(dwell_lo), .det_en(det_en),
        .frc_en(frc_en), .frc_val(frc_val), .fd_o(fd_o));

    // Reference model built from the requirements (R2..R8, R10)
    always @(posedge clk) begin
        if (!rst_n || !det_en) begin
            mf = 0; mc = 0;
        end else if (smp_vld) begin
            if (smp_mag > mU) begin
                mf = 1; mc = 0;
            end else if (mf && smp_mag < mL) begin
                if (mc >= int'(mD)) begin mf = 0; mc = 0; end
                else mc = mc + 1;
            end else begin
                mc = 0;
            end
        end
    end

    function automatic logic exp_pin();
        if (frc_en) return frc_val;
        if (det_en) return logic'(mf);
        return 1'b0;
    endfunction

    task automatic check_pin(input string tag);
        logic e;
        e = exp_pin();
        nvec++;
        if (fd_o !== e) begin
            nbad++;
            $display("FAIL %s: fd_o=%b expected %b", tag, fd_o, e);
        end
    endtask

    task automatic apply(input logic [12:0] m, input logic v, input string tag);
        @(negedge clk);
        smp_mag = m;
        smp_vld = v;
        @(posedge clk);
        #1;
        check_pin(tag);
        smp_vld = 1'b0;
    endtask

    // R1: bits 7:5 of the high bytes are filled with junk; only 4:0 matter
    task automatic cfg(input logic [12:0] u, input logic [12:0] l, input logic [15:0] d);
        @(negedge clk);
        mU = u; mL = l; mD = d;
        set_hi = {3'b101, u[12:8]}; set_lo = u[7:0];
        rel_hi = {3'b011, l[12:8]}; rel_lo = l[7:0];
        dwell_hi = d[15:8]; dwell_lo = d[7:0];
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        // R10: reset state
        repeat (3) @(negedge clk);
        det_en = 1'b1;
        @(posedge clk); #1;
        check_pin("R10");
        @(negedge clk);
        rst_n = 1'b1;

        // R1 and R2: sweep around the set threshold, equality does not set
        cfg(13'h1A5, 13'h0F0, 16'd0);
        for (int k = -3; k <= 3; k++) begin
            apply(13'd0, 1'b1, "R5");
            apply(13'(int'(13'h1A5) + k), 1'b1, "R2");
        end
        apply(13'd0, 1'b1, "R5");

        // R3 and R5: dwell 0..6, release after D+1 below samples
        for (int d = 0; d <= 6; d++) begin
            cfg(13'd800, 13'd300, 16'(d));
            apply(13'd801, 1'b1, "R2");
            for (int n = 0; n < d + 2; n++)
                apply(13'(n * 37), 1'b1, (d == 0) ? "R5" : "R3");
        end

        // R4: a sample at the release threshold restarts the count
        cfg(13'd800, 13'd300, 16'd4);
        apply(13'd900, 1'b1, "R2");
        repeat (3) apply(13'd10, 1'b1, "R4");
        apply(13'd300, 1'b1, "R4");
        for (int n = 0; n < 6; n++) apply(13'd299, 1'b1, "R4");

        // R6: release threshold above set threshold; above-set samples hold the flag
        cfg(13'd100, 13'd200, 16'd1);
        apply(13'd150, 1'b1, "R6");
        for (int n = 0; n < 5; n++) apply(13'd150, 1'b1, "R6");
        apply(13'd100, 1'b1, "R6");
        apply(13'd100, 1'b1, "R6");
        apply(13'd100, 1'b1, "R6");

        // R7: unstrobed cycles do not advance the dwell
        cfg(13'd800, 13'd300, 16'd3);
        apply(13'd999, 1'b1, "R2");
        for (int n = 0; n < 12; n++)
            apply(13'd5, (n % 3) == 0, "R7");
        for (int n = 0; n < 4; n++) apply(13'd5, 1'b1, "R7");

        // R8: disabling clears flag and count
        apply(13'd999, 1'b1, "R2");
        apply(13'd5, 1'b1, "R8");
        @(negedge clk); det_en = 1'b0; #1; check_pin("R8");
        apply(13'd999, 1'b1, "R8");
        @(negedge clk); det_en = 1'b1; #1; check_pin("R8");
        repeat (5) apply(13'd5, 1'b1, "R8");

        // R9: override for every combination of enable, value and flag
        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            det_en = 1'b1; frc_en = 1'b0;
            apply((s & 4) ? 13'd999 : 13'd0, 1'b1, "R9");
            apply(13'd0, 1'b1, "R9");
            @(negedge clk);
            det_en = s[0]; frc_en = 1'b1; frc_val = s[1];
            #1; check_pin("R9");
            frc_val = ~frc_val;
            #1; check_pin("R9");
            @(negedge clk); frc_en = 1'b0; det_en = 1'b1;
            #1; check_pin("R9");
        end

        // R1: dwell high byte counts (258 below samples hold, 259th releases)
        cfg(13'd800, 13'd300, 16'h0102);
        apply(13'd801, 1'b1, "R2");
        for (int n = 0; n < 262; n++) apply(13'd1, 1'b1, "R1");

        // R3: pseudo-random magnitudes near both thresholds with sparse strobes
        cfg(13'h0C40, 13'h0A10, 16'd5);
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            apply(13'(int'(13'h0A00) + int'(lfsr[9:0])), lfsr[11] | lfsr[12], "R3");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule